// File: doc/BRIEF.md
# ADC Serial Frame Capture Controller

This block is the master side of a three-wire synchronous link to a 12-bit sampling converter. It drives a conversion strobe and a serial clock derived from the system clock. It then reads a 16-bit frame from the converter's data line and returns the 12-bit result with a one-cycle valid pulse. A frame starts with a strobe that lasts one serial period. Sixteen serial periods follow, and the data line is sampled once in each.

The frame layout is fixed. The first three bits sampled are zero padding, the next twelve are the result with the most significant bit first, and the last bit is zero padding. If any padding position reads as one, the frame is reported as malformed and no result is delivered.

The controller runs a single frame on request, or frames back to back while continuous mode is held. A held result register is acknowledged by the consumer. A result that arrives before the previous one was acknowledged raises an overrun flag.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While idle (`busy_o` low), `cnvst_o` is low and `sclk_o` sits at the level chosen by `mode_i`: low for mode 0 (polarity 0, phase 0) and high for mode 1 (polarity 1, phase 1).
- R2: When idle, a high `start_i` makes `cnvst_o` high from the next clock edge. It stays high for exactly one serial period, and no data bit is sampled during it.
- R3: After the strobe falls, a frame contains exactly 16 rising edges of `sclk_o`. The data line is sampled once per rising edge, and both modes use the rising edge for this.
- R4: Frame bit k is the value sampled at the (k+1)-th rising edge. Bits 0 to 2 are padding, bits 3 to 14 are the result from bit 11 down to bit 0, and bit 15 is padding. `sample_o` then holds the result.
- R5: For a well-formed frame, `valid_o` is high for exactly one system clock, in the cycle after the 16th serial period ends.
- R6: If any of the four padding bits is one, `fmt_err_o` pulses for one cycle in place of `valid_o`, and `sample_o` keeps its previous value.
- R7: The serial half-period is `div_half_i` system clocks, with 0 treated as 1. This gives an even division of at least 2. The value is captured when a start is accepted.
- R8: When `cont_i` is high at the end of a frame, the next strobe begins at once. Strobe rising edges are then 17 serial periods (34 × half-period clocks) apart. When `cont_i` is low at the end of a frame, the controller returns to idle.
- R9: `start_i` is ignored while a frame or strobe is in progress.
- R10: `overrun_o` is set when a new result is written while the previous result is still unacknowledged. A high `ack_i` acknowledges the held result and clears `overrun_o`.
- R11: The data line is ignored outside the 16 sampling edges of a frame. Ones driven there do not cause a format error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| cont_i | input | 1 | Continuous mode: start the next frame at the end of each frame |
| mode_i | input | 1 | Clock mode: 0 idles low, 1 idles high |
| div_half_i | input | 8 | Serial half-period in system clocks (0 means 1) |
| ack_i | input | 1 | Acknowledge of the held result |
| sdata_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock |
| cnvst_o | output | 1 | Conversion/frame strobe |
| busy_o | output | 1 | Strobe or frame in progress |
| sample_o | output | 12 | Last well-formed result |
| valid_o | output | 1 | One-cycle pulse when a new result is written |
| fmt_err_o | output | 1 | One-cycle pulse for a frame with a nonzero padding bit |
| overrun_o | output | 1 | A result was overwritten before it was acknowledged |

## Verification
The hardest situation to reach is an overrun. It needs two results in a row with no acknowledge between them, and in continuous mode those results also have to arrive at the exact back-to-back spacing. The bench reaches it by turning off its automatic acknowledge and holding continuous mode for two frames. It checks that `overrun_o` stays low after the first result, rises with the second, and clears once an acknowledge is given. A malformed frame placed in the middle of a continuous run checks that an error neither delivers a result nor breaks the frame spacing.

// File: rtl/adc_fc_pkg.sv
// Shared types for the ADC frame capture controller.
package adc_fc_pkg;

    // Controller phase: idle, strobe period, or data shifting.
    typedef enum logic [1:0] {
        FC_IDLE   = 2'd0,
        FC_STROBE = 2'd1,
        FC_SHIFT  = 2'd2
    } fc_state_e;

endpackage

// File: rtl/adc_fc_sclk_gen.sv
// Serial clock phase generator.
// Divides the system clock by 2*half_i. It emits a rise pulse when the phase
// goes from low to high (the sampling point) and a fall pulse when a serial
// period ends.
// Assumes half_i >= 1 and stable while run_i is high.
module adc_fc_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             rise_o,
    output logic             fall_o,
    output logic             phase_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             ph_q;
    logic             tick;

    assign tick    = run_i && (cnt_q == half_i - DIV_W'(1));
    assign rise_o  = tick && !ph_q;
    assign fall_o  = tick && ph_q;
    assign phase_o = ph_q;

    // Half-period counter and phase toggle; both held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            ph_q  <= ~ph_q;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/adc_fc_frame_shift.sv
// Frame shift register and layout decoder.
// Shifts in one bit per shift_i, MSB first. It presents the result field and
// a padding error built from the leading and trailing padding positions.
// Assumes the caller shifts exactly LEAD_PAD+DATA_W+TRAIL_PAD bits per frame.
module adc_fc_frame_shift #(
    parameter int DATA_W    = 12,
    parameter int LEAD_PAD  = 3,
    parameter int TRAIL_PAD = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] data_o,
    output logic              pad_err_o
);
    localparam int FRAME_LEN = LEAD_PAD + DATA_W + TRAIL_PAD;

    logic [FRAME_LEN-1:0] sh_q;
    logic                 lead_err;
    logic                 trail_err;

    // Serial-in shift register, first bit ends up in the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (shift_i) begin
            sh_q <= {sh_q[FRAME_LEN-2:0], bit_i};
        end
    end

    assign data_o = sh_q[TRAIL_PAD +: DATA_W];

    generate
        if (LEAD_PAD > 0) begin : g_lead
            assign lead_err = |sh_q[FRAME_LEN-1 -: LEAD_PAD];
        end else begin : g_nolead
            assign lead_err = 1'b0;
        end
        if (TRAIL_PAD > 0) begin : g_trail
            assign trail_err = |sh_q[TRAIL_PAD-1:0];
        end else begin : g_notrail
            assign trail_err = 1'b0;
        end
    endgenerate

    assign pad_err_o = lead_err | trail_err;
endmodule

// File: rtl/adc_fc_result.sv
// Result holding register with valid/error pulses and overrun tracking.
// On done_i it writes a well-formed result (valid pulse) or reports an error
// pulse and leaves the held result alone. An unacknowledged result that is
// overwritten sets the sticky overrun flag until ack_i.
module adc_fc_result #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              err_i,
    input  logic              ack_i,
    output logic [DATA_W-1:0] sample_o,
    output logic              valid_o,
    output logic              fmt_err_o,
    output logic              overrun_o
);
    logic pend_q;
    logic write;

    assign write = done_i && !err_i;

    // Result register and one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o  <= '0;
            valid_o   <= 1'b0;
            fmt_err_o <= 1'b0;
        end else begin
            valid_o   <= write;
            fmt_err_o <= done_i && err_i;
            if (write) begin
                sample_o <= data_i;
            end
        end
    end

    // Pending/overrun bookkeeping; an ack in the write cycle retires the old result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            overrun_o <= 1'b0;
        end else if (write) begin
            pend_q    <= 1'b1;
            overrun_o <= (pend_q || overrun_o) && !ack_i;
        end else if (ack_i) begin
            pend_q    <= 1'b0;
            overrun_o <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_frame_ctrl.sv
// ADC serial frame capture controller (top).
// Sequences idle -> strobe (one serial period) -> 16 sampled serial periods.
// It then returns to idle, or to a new strobe in continuous mode.
// Sampling uses the internal phase edge that raises sclk_o, so both clock
// modes sample on the rising edge. The modes differ only in idle level.
// Assumes the converter changes data on falling sclk edges.
module adc_frame_ctrl #(
    parameter int DATA_W    = 12,
    parameter int LEAD_PAD  = 3,
    parameter int TRAIL_PAD = 1,
    parameter int DIV_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic              mode_i,
    input  logic [DIV_W-1:0]  div_half_i,
    input  logic              ack_i,
    input  logic              sdata_i,
    output logic              sclk_o,
    output logic              cnvst_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] sample_o,
    output logic              valid_o,
    output logic              fmt_err_o,
    output logic              overrun_o
);
    import adc_fc_pkg::*;

    localparam int FRAME_LEN = LEAD_PAD + DATA_W + TRAIL_PAD;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);

    fc_state_e         state_q;
    logic [DIV_W-1:0]  half_q;
    logic [CNT_W-1:0]  bit_q;
    logic              run;
    logic              rise;
    logic              fall;
    logic              phase;
    logic              frame_end;
    logic [DATA_W-1:0] frame_data;
    logic              frame_err;

    assign run       = (state_q != FC_IDLE);
    assign frame_end = (state_q == FC_SHIFT) && fall && (bit_q == LAST_BIT);

    // Sequencer: accepts starts only when idle, counts serial periods per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FC_IDLE;
            half_q  <= DIV_W'(1);
            bit_q   <= '0;
        end else begin
            case (state_q)
                FC_IDLE: begin
                    if (start_i) begin
                        state_q <= FC_STROBE;
                        half_q  <= (div_half_i == '0) ? DIV_W'(1) : div_half_i;
                    end
                end
                FC_STROBE: begin
                    if (fall) begin
                        state_q <= FC_SHIFT;
                        bit_q   <= '0;
                    end
                end
                FC_SHIFT: begin
                    if (fall) begin
                        if (bit_q == LAST_BIT) begin
                            state_q <= cont_i ? FC_STROBE : FC_IDLE;
                        end else begin
                            bit_q <= bit_q + CNT_W'(1);
                        end
                    end
                end
                default: state_q <= FC_IDLE;
            endcase
        end
    end

    adc_fc_sclk_gen #(
        .DIV_W (DIV_W)
    ) u_sclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .half_i  (half_q),
        .rise_o  (rise),
        .fall_o  (fall),
        .phase_o (phase)
    );

    adc_fc_frame_shift #(
        .DATA_W    (DATA_W),
        .LEAD_PAD  (LEAD_PAD),
        .TRAIL_PAD (TRAIL_PAD)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_i   (rise && (state_q == FC_SHIFT)),
        .bit_i     (sdata_i),
        .data_o    (frame_data),
        .pad_err_o (frame_err)
    );

    adc_fc_result #(
        .DATA_W (DATA_W)
    ) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (frame_end),
        .data_i    (frame_data),
        .err_i     (frame_err),
        .ack_i     (ack_i),
        .sample_o  (sample_o),
        .valid_o   (valid_o),
        .fmt_err_o (fmt_err_o),
        .overrun_o (overrun_o)
    );

    assign sclk_o  = run ? phase : mode_i;
    assign cnvst_o = (state_q == FC_STROBE);
    assign busy_o  = run;
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
// Port-level protocol checker for adc_frame_ctrl, attached by bind.
// Observes only top-level ports; relates strobe, clock level, pulses and flags.
module adc_frame_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic mode_i,
    input logic ack_i,
    input logic sclk_o,
    input logic cnvst_o,
    input logic busy_o,
    input logic valid_o,
    input logic fmt_err_o,
    input logic overrun_o
);
    assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cnvst_o && (sclk_o == mode_i)));

    assert_start_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> cnvst_o);

    assert_strobe_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnvst_o |-> busy_o);

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && fmt_err_o));

    assert_no_pulse_in_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnvst_o && $past(cnvst_o)) |-> !(valid_o || fmt_err_o));

    assert_overrun_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> valid_o);

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack_i) && !valid_o) |-> !overrun_o);
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .ack_i     (ack_i),
    .sclk_o    (sclk_o),
    .cnvst_o   (cnvst_o),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .fmt_err_o (fmt_err_o),
    .overrun_o (overrun_o)
);

// File: tb/adc_frame_ctrl_bench.sv
// Scoreboard bench: a driver queues frames for a converter model and expected
// outcomes for a monitor that compares them as frames complete.
module adc_frame_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cont_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [7:0]  div_half_i = 8'd1;
    logic        ack_i = 1'b0;
    logic        sdata_i = 1'b1;
    logic        sclk_o, cnvst_o, busy_o, valid_o, fmt_err_o, overrun_o;
    logic [11:0] sample_o;

    adc_frame_ctrl u_adc_frame_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .mode_i(mode_i), .div_half_i(div_half_i), .ack_i(ack_i),
        .sdata_i(sdata_i), .sclk_o(sclk_o), .cnvst_o(cnvst_o),
        .busy_o(busy_o), .sample_o(sample_o), .valid_o(valid_o),
        .fmt_err_o(fmt_err_o), .overrun_o(overrun_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          done_cnt = 0;
    int          cyc = 0;
    int          cur_half = 1;
    int          last_rise = -1;
    int          hi_cnt = 0;
    int          rise_cnt = 0;
    int          bitpos = 0;
    logic        chk_period = 1'b0;
    logic        auto_ack = 1'b1;
    logic        man_ack = 1'b0;
    logic        prev_cnvst = 1'b0;
    logic        prev_sclk = 1'b0;
    logic        valid_d = 1'b0;
    logic        finished = 1'b0;
    logic [15:0] cur_word = '0;
    logic [11:0] last_good = '0;
    logic [15:0] tx_q[$];
    logic [12:0] exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: queue a frame for the converter model and its expected outcome.
    task automatic push_frame(input logic [2:0] lead, input logic [11:0] d, input logic trail);
        tx_q.push_back({lead, d, trail});
        exp_q.push_back({(lead != 3'b000) || trail, d});
    endtask

    task automatic run_single(input int half, input logic mode);
        int base;
        base = done_cnt;
        @(negedge clk);
        div_half_i = 8'(half);
        mode_i     = mode;
        cont_i     = 1'b0;
        cur_half   = (half == 0) ? 1 : half;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait (done_cnt == base + 1);
        @(negedge clk);
    endtask

    // Monitor, scoreboard and converter model, all at the inactive edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cnvst_o && !prev_cnvst) begin
                if (chk_period && last_rise >= 0)
                    check(cyc - last_rise == 34 * cur_half, "R8 strobe spacing", cyc - last_rise, 34 * cur_half);
                last_rise = cyc;
                hi_cnt = 0;
            end
            if (cnvst_o) hi_cnt++;
            if (!cnvst_o && prev_cnvst) begin
                check(hi_cnt == 2 * cur_half, "R2/R7 strobe width", hi_cnt, 2 * cur_half);
                rise_cnt = 0;
            end
            if (sclk_o && !prev_sclk && busy_o && !cnvst_o) rise_cnt++;
            if (valid_o && valid_d) check(1'b0, "R5 valid longer than one cycle", 2, 1);
            if (valid_o || fmt_err_o) begin
                done_cnt++;
                check(rise_cnt == 16, "R3 rising edges per frame", rise_cnt, 16);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected frame", 1, 0);
                end else begin
                    logic [12:0] e;
                    e = exp_q.pop_front();
                    check(fmt_err_o == e[12], "R6/R11 format error flag", fmt_err_o, e[12]);
                    check(!(valid_o && fmt_err_o), "R6 exclusive pulses", valid_o, 0);
                    if (!e[12]) begin
                        check(sample_o == e[11:0], "R4 result value", sample_o, e[11:0]);
                        last_good = e[11:0];
                    end else begin
                        check(sample_o == last_good, "R6 result held", sample_o, last_good);
                    end
                end
            end
            ack_i = (auto_ack && valid_o) || man_ack;
            // Converter model: loads a frame when the strobe falls, advances on sclk fall.
            if (!cnvst_o && prev_cnvst) begin
                cur_word = (tx_q.size() > 0) ? tx_q.pop_front() : 16'h0000;
                bitpos   = 15;
                sdata_i  = cur_word[15];
            end else if (cnvst_o || !busy_o) begin
                sdata_i = 1'b1;
            end else if (prev_sclk && !sclk_o && bitpos > 0) begin
                bitpos--;
                sdata_i = cur_word[bitpos];
            end
        end
        prev_cnvst = cnvst_o;
        prev_sclk  = sclk_o;
        valid_d    = valid_o;
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset/idle state in mode 0
        check(sclk_o == 1'b0, "R1 idle sclk mode0", sclk_o, 0);
        check(cnvst_o == 1'b0 && busy_o == 1'b0, "R1 idle strobe/busy", {cnvst_o, busy_o}, 0);
        check(valid_o == 1'b0 && overrun_o == 1'b0, "R5 no pulse after reset", {valid_o, overrun_o}, 0);
        mode_i = 1'b1;
        @(negedge clk);
        check(sclk_o == 1'b1, "R1 idle sclk mode1", sclk_o, 1);

        // R3 R4 R7: well-formed frames over both modes and several dividers
        push_frame(3'b000, 12'hA5C, 1'b0); run_single(1, 1'b0);
        check(sclk_o == 1'b0 && !busy_o, "R1 back to idle mode0", sclk_o, 0);
        push_frame(3'b000, 12'hFFF, 1'b0); run_single(2, 1'b1);
        check(sclk_o == 1'b1 && !busy_o, "R1 back to idle mode1", sclk_o, 1);
        push_frame(3'b000, 12'h001, 1'b0); run_single(0, 1'b0);
        push_frame(3'b000, 12'h800, 1'b0); run_single(3, 1'b1);

        // R6: leading and trailing padding errors
        push_frame(3'b010, 12'h123, 1'b0); run_single(1, 1'b0);
        push_frame(3'b000, 12'h7E5, 1'b1); run_single(2, 1'b1);
        push_frame(3'b100, 12'h0F0, 1'b0); run_single(1, 1'b1);

        // R9: a start during a frame is ignored
        base = done_cnt;
        push_frame(3'b000, 12'h3C3, 1'b0);
        @(negedge clk);
        div_half_i = 8'd2; cur_half = 2; mode_i = 1'b0; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (20) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait (done_cnt == base + 1);
        repeat (200) @(negedge clk);
        check(done_cnt == base + 1 && !busy_o, "R9 start ignored while busy", done_cnt - base, 1);

        // R8: continuous run of three frames with an error frame in the middle
        base = done_cnt;
        push_frame(3'b000, 12'h111, 1'b0);
        push_frame(3'b001, 12'h222, 1'b0);
        push_frame(3'b000, 12'h333, 1'b0);
        @(negedge clk);
        last_rise = -1; chk_period = 1'b1;
        div_half_i = 8'd2; cur_half = 2; cont_i = 1'b1; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait (done_cnt == base + 2);
        @(negedge clk); cont_i = 1'b0;
        wait (done_cnt == base + 3);
        repeat (100) @(negedge clk);
        check(!busy_o && done_cnt == base + 3, "R8 stops when continuous drops", done_cnt - base, 3);
        chk_period = 1'b0;

        // R10: two results without acknowledge
        base = done_cnt;
        auto_ack = 1'b0;
        push_frame(3'b000, 12'h456, 1'b0);
        push_frame(3'b000, 12'h789, 1'b0);
        @(negedge clk);
        div_half_i = 8'd1; cur_half = 1; cont_i = 1'b1; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait (done_cnt == base + 1);
        check(overrun_o == 1'b0, "R10 no overrun on first result", overrun_o, 0);
        @(negedge clk); cont_i = 1'b0;
        wait (done_cnt == base + 2);
        check(overrun_o == 1'b1, "R10 overrun on unacknowledged result", overrun_o, 1);
        @(posedge clk); man_ack = 1'b1;
        repeat (3) @(negedge clk);
        @(posedge clk); man_ack = 1'b0;
        repeat (3) @(negedge clk);
        check(overrun_o == 1'b0, "R10 ack clears overrun", overrun_o, 0);
        check(sample_o == 12'h789, "R10 newest result kept", sample_o, 12'h789);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", done_cnt, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule